// File: doc/BRIEF.md
# Idle-Timer Automatic Power-Down Controller

This block decides when a peripheral cluster may stop its internal clock. It watches two serial receive lines and a strobe that pulses on every register read or write. While both serial lines rest at the mark level and no register access takes place, it counts cycles of the free-running oscillator. When the selected timeout passes without any activity, it reports the automatic power-down code and drops the clock-enable output. The oscillator keeps running and is never touched by this block.

Any activity during power-down raises the clock enable again at once and reports the standby code. No oscillator settling wait is inserted. From standby the countdown starts again from the full timeout, so a quiet system returns to power-down by itself. The clock-gating cell and the peripherals lie outside the block.

The counter, the input synchronizers and the mode register all run on the oscillator clock. The register-access strobe is assumed to be synchronous to that clock. The serial lines are treated as asynchronous.

Top module: `idle_pd_ctrl`

## Requirements
- R1: After reset is released, `pwr_mode` reads 2'b10 (standby) and `clk_en` is 1.
- R2: With both serial lines held high, `pwr_mode` changes from 2'b10 to 2'b11 (automatic power-down) exactly N cycles after the last cycle in which `reg_acc` was sampled high. N = 2^(BASE_LOG2 + 2*`tmo_sel`).
- R3: The four `tmo_sel` codes 0, 1, 2 and 3 select N = 2^BASE_LOG2, 2^(BASE_LOG2+2), 2^(BASE_LOG2+4) and 2^(BASE_LOG2+6) respectively.
- R4: `clk_en` is 0 exactly when `pwr_mode` is 2'b11, and is 1 otherwise.
- R5: A `reg_acc` pulse sampled while in power-down makes `pwr_mode` 2'b10 and `clk_en` 1 on the very next cycle.
- R6: A serial line going low while in power-down makes `clk_en` 1 and `pwr_mode` 2'b10 within 4 cycles.
- R7: A `reg_acc` pulse during the countdown restarts it, so that power-down follows N cycles after that pulse rather than after the earlier one.
- R8: While either serial line is held low, `pwr_mode` stays 2'b10 however long the condition lasts.
- R9: After a wake-up, if the system stays quiet, the countdown runs again from the full value and `pwr_mode` returns to 2'b11.
- R10: A short low pulse on a serial line during the countdown restarts the timer. Power-down then comes no earlier than N cycles after the pulse.
- R11: `pwr_mode` never takes a value with bit 1 clear; only 2'b10 and 2'b11 occur.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_osc | input | 1 | Free-running oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_rx_a | input | 1 | First serial receive line, idle high, asynchronous |
| ser_rx_b | input | 1 | Second serial receive line, idle high, asynchronous |
| reg_acc | input | 1 | One-cycle strobe on every register read or write |
| tmo_sel | input | 2 | Timeout select code |
| pwr_mode | output | 2 | Power-mode status: 2'b10 standby, 2'b11 power-down |
| clk_en | output | 1 | Internal clock enable for the gating cell |

## Verification
The countdown is driven with a single register strobe on quiet lines, at each of the four timeout codes. This separates the four lengths and pins the expiry to its exact cycle. A second strobe part-way through the count is then applied; it tells a timer that restarts apart from one that only pauses. Serial lines are exercised both held low and with brief low pulses, which separates a level-qualified idle condition from an edge-only one. Wake-ups come from the strobe and from each serial line, and each is followed by a quiet stretch to confirm the return to power-down.

// File: rtl/ipd_pkg.sv
// Package: shared encodings and helpers for the idle-timer power-down block.
// Assumes the timeout exponent grows by two per select code.
package ipd_pkg;

    typedef enum logic [1:0] {
        PM_STANDBY = 2'b10,
        PM_AUTOPD  = 2'b11
    } pwr_mode_e;

    // Timeout length in cycles for a select code.
    function automatic int unsigned tmo_cycles(input int unsigned base_log2,
                                               input logic [1:0] sel);
        return 32'd1 << (base_log2 + 2 * int'(sel));
    endfunction

endpackage

// File: rtl/ipd_sync2.sv
// Module: two-flop synchronizer, one lane per bit.
// Assumes the inputs are asynchronous to clk. Reset loads RST_VAL into both stages.
module ipd_sync2 #(
    parameter int          W       = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    for (genvar i = 0; i < W; i++) begin : g_lane
        logic s1, s2;
        // Two-stage capture of one asynchronous bit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s1 <= RST_VAL;
                s2 <= RST_VAL;
            end else begin
                s1 <= din[i];
                s2 <= s1;
            end
        end
        assign dout[i] = s2;
    end
endmodule

// File: rtl/ipd_activity.sv
// Module: activity qualifier. It flags a cycle as busy when any serial line is
// low, when any line changed since the last cycle, or when a register access
// strobe is present. Assumes the serial lines are already synchronized.
module ipd_activity #(
    parameter int NLINES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] line_sync,
    input  logic              reg_acc,
    output logic              busy
);
    logic [NLINES-1:0] line_prev;

    // Remember the previous synchronized level for change detection.
    always_ff @(posedge clk) begin
        if (!rst_n) line_prev <= '1;
        else        line_prev <= line_sync;
    end

    // Combine level, change and access conditions.
    always_comb begin
        busy = reg_acc;
        for (int i = 0; i < NLINES; i++) begin
            if (!line_sync[i] || (line_sync[i] != line_prev[i])) busy = 1'b1;
        end
    end
endmodule

// File: rtl/ipd_timer.sv
// Module: idle countdown. It counts quiet cycles up to the selected limit and
// raises expire in the cycle that completes the count. It holds while powered
// down and clears on any busy cycle. Assumes busy is synchronous to clk.
module ipd_timer
    import ipd_pkg::*;
#(
    parameter int BASE_LOG2 = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       busy,
    input  logic       in_pd,
    input  logic [1:0] tmo_sel,
    output logic       expire
);
    localparam int MAX_LOG2 = BASE_LOG2 + 6;
    localparam int CW       = MAX_LOG2 + 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] last;

    // Terminal count for the selected timeout.
    always_comb begin
        last = CW'(tmo_cycles(BASE_LOG2, tmo_sel) - 1);
    end

    // Expiry fires on the final quiet cycle, only outside power-down.
    always_comb begin
        expire = !busy && !in_pd && (cnt >= last);
    end

    // Quiet-cycle counter: cleared by activity, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || busy)              cnt <= '0;
        else if (!in_pd && cnt < last)   cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/idle_pd_ctrl.sv
// Module: top of the idle-timer automatic power-down controller. It
// synchronizes the serial lines, qualifies activity, runs the countdown and
// keeps the power-mode register that drives the clock enable.
// Assumes clk_osc never stops and reg_acc is synchronous to it.
module idle_pd_ctrl
    import ipd_pkg::*;
#(
    parameter int BASE_LOG2 = 12
) (
    input  logic       clk_osc,
    input  logic       rst_n,
    input  logic       ser_rx_a,
    input  logic       ser_rx_b,
    input  logic       reg_acc,
    input  logic [1:0] tmo_sel,
    output logic [1:0] pwr_mode,
    output logic       clk_en
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] line_sync;
    logic              busy;
    logic              expire;
    pwr_mode_e         mode_q;

    ipd_sync2 #(.W(NLINES), .RST_VAL(1'b1)) u_sync (
        .clk  (clk_osc),
        .rst_n(rst_n),
        .din  ({ser_rx_b, ser_rx_a}),
        .dout (line_sync)
    );

    ipd_activity #(.NLINES(NLINES)) u_act (
        .clk      (clk_osc),
        .rst_n    (rst_n),
        .line_sync(line_sync),
        .reg_acc  (reg_acc),
        .busy     (busy)
    );

    ipd_timer #(.BASE_LOG2(BASE_LOG2)) u_tmr (
        .clk    (clk_osc),
        .rst_n  (rst_n),
        .busy   (busy),
        .in_pd  (mode_q == PM_AUTOPD),
        .tmo_sel(tmo_sel),
        .expire (expire)
    );

    // Mode register: activity forces standby, expiry enters power-down.
    always_ff @(posedge clk_osc) begin
        if (!rst_n)      mode_q <= PM_STANDBY;
        else if (busy)   mode_q <= PM_STANDBY;
        else if (expire) mode_q <= PM_AUTOPD;
    end

    assign pwr_mode = mode_q;
    assign clk_en   = (mode_q != PM_AUTOPD);
endmodule

// File: rtl/ipd_checker.sv
// Module: assertion checker for idle_pd_ctrl, bound to the top module.
// It keeps its own count of quiet cycles seen at the pins.
module ipd_checker #(
    parameter int BASE_LOG2 = 12
) (
    input logic       clk_osc,
    input logic       rst_n,
    input logic       ser_rx_a,
    input logic       ser_rx_b,
    input logic       reg_acc,
    input logic [1:0] pwr_mode,
    input logic       clk_en
);
    logic [31:0] quiet_cnt;

    // Count cycles since the last pin-level activity, saturating.
    always_ff @(posedge clk_osc) begin
        if (!rst_n || reg_acc || !ser_rx_a || !ser_rx_b) quiet_cnt <= '0;
        else if (quiet_cnt != 32'hFFFF_FFFF)             quiet_cnt <= quiet_cnt + 1'b1;
    end

    p_mode_legal_r11: assert property (@(posedge clk_osc) disable iff (!rst_n)
        pwr_mode[1] == 1'b1);

    p_no_early_pd_r2: assert property (@(posedge clk_osc) disable iff (!rst_n)
        $rose(pwr_mode == 2'b11) |-> quiet_cnt >= (32'd1 << BASE_LOG2));

    p_wake_access_r5: assert property (@(posedge clk_osc) disable iff (!rst_n)
        reg_acc |=> (pwr_mode == 2'b10) && clk_en);

    p_clk_rise_r4: assert property (@(posedge clk_osc) disable iff (!rst_n)
        $rose(clk_en) |-> pwr_mode == 2'b10);

    p_clk_fall_r4: assert property (@(posedge clk_osc) disable iff (!rst_n)
        $fell(clk_en) |-> pwr_mode == 2'b11);
endmodule

bind idle_pd_ctrl ipd_checker #(.BASE_LOG2(BASE_LOG2)) u_chk (
    .clk_osc (clk_osc),
    .rst_n   (rst_n),
    .ser_rx_a(ser_rx_a),
    .ser_rx_b(ser_rx_b),
    .reg_acc (reg_acc),
    .pwr_mode(pwr_mode),
    .clk_en  (clk_en)
);

// File: tb/sim_idle_pd_ctrl.sv
// Directed bench for idle_pd_ctrl with a short timeout base.
module sim_idle_pd_ctrl;
    localparam int BASE = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_a = 1'b1, rx_b = 1'b1, acc = 1'b0;
    logic [1:0] sel = 2'd0;
    logic [1:0] mode;
    logic       cen;
    int         total = 0, bad = 0;

    always #5 clk = ~clk;

    idle_pd_ctrl #(.BASE_LOG2(BASE)) u0 (
        .clk_osc(clk), .rst_n(rst_n), .ser_rx_a(rx_a), .ser_rx_b(rx_b),
        .reg_acc(acc), .tmo_sel(sel), .pwr_mode(mode), .clk_en(cen)
    );

    function automatic int tmo(input logic [1:0] s);
        return 1 << (BASE + 2 * int'(s));
    endfunction

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(input string req, input logic [1:0] m_exp, input logic c_exp);
        total++;
        if (mode !== m_exp || cen !== c_exp) begin
            bad++;
            $display("FAIL %s: mode=%b clk_en=%b expected mode=%b clk_en=%b",
                     req, mode, cen, m_exp, c_exp);
        end
    endtask

    task automatic pulse_acc();
        acc = 1'b1;
        step();
        acc = 1'b0;
    endtask

    // R2 R3 R4: exact expiry point for a timeout code
    task automatic t_expiry(input logic [1:0] s);
        sel = s;
        pulse_acc();
        step(tmo(s) - 1);
        chk("R2/R3 before expiry", 2'b10, 1'b1);
        step();
        chk("R2/R3 R4 at expiry", 2'b11, 1'b0);
    endtask

    // R5: strobe wakes on next cycle
    task automatic t_wake_acc();
        pulse_acc();
        chk("R5 access wake", 2'b10, 1'b1);
    endtask

    // R7: mid-count strobe restarts timer
    task automatic t_restart();
        sel = 2'd1;
        pulse_acc();
        step(tmo(1) / 2);
        pulse_acc();
        step(tmo(1) - 1);
        chk("R7 restart not yet", 2'b10, 1'b1);
        step();
        chk("R7 restart expiry", 2'b11, 1'b0);
    endtask

    // R6 R9: serial wake, then return to power-down
    task automatic t_wake_serial(input bit line_b);
        bit seen = 0;
        if (line_b) rx_b = 1'b0; else rx_a = 1'b0;
        for (int i = 0; i < 4; i++) begin
            step();
            if (cen === 1'b1 && mode === 2'b10) seen = 1;
        end
        total++;
        if (!seen) begin
            bad++;
            $display("FAIL R6 serial wake: mode=%b clk_en=%b expected mode=10 clk_en=1", mode, cen);
        end
        rx_a = 1'b1; rx_b = 1'b1;
        step(tmo(sel) + 8);
        chk("R9 back to power-down", 2'b11, 1'b0);
    endtask

    // R8: held-low line blocks power-down
    task automatic t_held_low();
        sel = 2'd0;
        pulse_acc();
        rx_a = 1'b0;
        step(tmo(2'd2) + 20);
        chk("R8 held low", 2'b10, 1'b1);
        rx_a = 1'b1;
        step(tmo(0) + 8);
        chk("R8 release then idle", 2'b11, 1'b0);
    endtask

    // R10: short serial pulse restarts timer
    task automatic t_glitch();
        sel = 2'd1;
        pulse_acc();
        step(tmo(1) - 6);
        rx_b = 1'b0;
        step(2);
        rx_b = 1'b1;
        step(tmo(1) - 8);
        chk("R10 pulse restarts count", 2'b10, 1'b1);
        step(20);
        chk("R10 expiry after pulse", 2'b11, 1'b0);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step();
        chk("R1 reset state", 2'b10, 1'b1);
        step(4);
        t_expiry(2'd0);
        t_wake_acc();
        t_expiry(2'd1);
        t_wake_acc();
        t_expiry(2'd2);
        t_wake_acc();
        t_expiry(2'd3);
        t_wake_acc();
        t_restart();
        t_wake_serial(1'b0);
        t_wake_serial(1'b1);
        t_held_low();
        t_glitch();
        total++;
        if (mode[1] !== 1'b1) begin
            bad++;
            $display("FAIL R11 legal code: mode=%b expected 1x", mode);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1000000;
        total++;
        bad++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule